// File: doc/BRIEF.md
# Timer Slave Gating and Trigger Controller

This block is an up-counter whose run enable is controlled by a slave trigger. One of several trigger lines is selected, optionally inverted, and brought into the counter clock domain through a synchronizer. The counter always continues from the value it already holds; nothing in this block clears it except reset.

The block has two slave modes. In the gated mode the synchronized trigger level is the run enable, so the counter runs while the trigger is high and freezes while it is low. In the resume mode a rising edge of the trigger turns the enable on. Only a software stop turns it off again, and the trigger's falling edge has no effect. Each mode refuses one source that cannot serve it: the gated mode refuses the source fed by the both-edge detector, which has no meaningful level, and the resume mode refuses the software update-event source, which gives no usable edge. A sticky event flag records every trigger rising edge until software clears it.

Top module: `tsg_top`

## Requirements
- R1: While `cnt_en` is 1 at a clock edge, `cnt` increases by exactly 1 at that edge. While `cnt_en` is 0, `cnt` holds its value.
- R2: In gated mode (`mode`=0), `cnt_en` follows the synchronized trigger level. When the trigger goes low the counter freezes at its present, nonzero value and is not cleared.
- R3: When `trig_inv`=1 the selected trigger is inverted before level and edge detection, so a low line counts as active.
- R4: In resume mode (`mode`=1), a trigger rising edge sets `cnt_en`, and counting continues from the held value.
- R5: In resume mode, a trigger falling edge or low level leaves `cnt_en` unchanged.
- R6: In resume mode, `sw_stop`=1 clears `cnt_en` at the next edge, and it wins over a rising edge in the same cycle. In gated mode `sw_stop` has no effect.
- R7: In gated mode, selecting source index 0 (the both-edge detector source) keeps `cnt_en` at 0 whatever that line does.
- R8: In resume mode, selecting source index 3 (the software update-event source) never sets `cnt_en`.
- R9: Two synchronizer stages are used. A trigger change applied before clock edge k shows on `cnt_en` after edge k+2 and not after edge k+1.
- R10: `trig_flag` is set by every rising edge of the conditioned trigger, in either mode and from any source. It stays set until `flag_clr`=1 clears it.
- R11: If `flag_clr` and a new trigger rising edge fall in the same cycle, `trig_flag` stays set.
- R12: Reset sets `cnt`, `cnt_en` and `trig_flag` to 0. After the all-ones value, `cnt` wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | NUM_SRC | Candidate trigger lines (index 0: both-edge source, index 3: software update-event source) |
| src_sel | input | SEL_W | Index of the trigger line in use |
| trig_inv | input | 1 | 1 inverts the selected trigger |
| mode | input | 1 | 0 gated mode, 1 resume mode |
| sw_stop | input | 1 | Software stop of the enable (resume mode) |
| flag_clr | input | 1 | Software clear of the event flag |
| cnt | output | CNT_W | Counter value |
| cnt_en | output | 1 | Counter run enable |
| trig_flag | output | 1 | Sticky trigger event flag |

## Verification
Two things can happen in one cycle here: a software flag clear can coincide with the cycle in which a synchronized rising edge sets the flag. The bench raises a trigger line, waits the two synchronizer edges, and then holds `flag_clr` high for exactly the edge at which the flag would be set. The flag must read 1 afterwards, and a later lone clear must bring it to 0. In resume mode, stop and edge can also coincide, and the enable rule gives the stop priority.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  typedef enum logic {
    MODE_GATED  = 1'b0,
    MODE_RESUME = 1'b1
  } slave_mode_e;
endpackage

// File: rtl/tsg_sync.sv
module tsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tsg_trig_front.sv
module tsg_trig_front #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               trig_inv,
  output logic               lvl,
  output logic               rise
);
  logic raw;
  logic lvl_prev;

  assign raw = trig_in[src_sel] ^ trig_inv;

  tsg_sync #(.STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) lvl_prev <= 1'b0;
    else     lvl_prev <= lvl;
  end

  assign rise = lvl & ~lvl_prev;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R10
endmodule

// File: rtl/tsg_enable_ctl.sv
module tsg_enable_ctl
  import tsg_pkg::*;
#(
  parameter int SEL_W    = 2,
  parameter int EDGE_SRC = 0,
  parameter int SWEV_SRC = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  slave_mode_e      mode,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             lvl,
  input  logic             rise,
  input  logic             sw_stop,
  output logic             en
);
  logic edge_src_bar;
  logic swev_src_bar;

  assign edge_src_bar = (src_sel == SEL_W'(EDGE_SRC));
  assign swev_src_bar = (src_sel == SEL_W'(SWEV_SRC));

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0;
    end else if (mode == MODE_GATED) begin
      en <= lvl & ~edge_src_bar;
    end else if (sw_stop) begin
      en <= 1'b0;
    end else if (rise && !swev_src_bar) begin
      en <= 1'b1;
    end
  end

  AST_RESUME_NO_STOP: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RESUME && en && !sw_stop) |=> en); // R5
  AST_SW_STOP: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RESUME && sw_stop) |=> !en); // R6
  AST_GATED_EDGE_BAR: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_GATED && edge_src_bar) |=> !en); // R7
  AST_SWEV_NO_RESUME: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_RESUME && swev_src_bar && !en) |=> !en); // R8
endmodule

// File: rtl/tsg_counter.sv
module tsg_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)     cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt == $past(cnt) + 1'b1); // R1
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt)); // R2
endmodule

// File: rtl/tsg_top.sv
module tsg_top
  import tsg_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int NUM_SRC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_SRC    = 0,
  parameter int SWEV_SRC    = 3,
  localparam int SEL_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] trig_in,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic               trig_inv,
  input  logic               mode,
  input  logic               sw_stop,
  input  logic               flag_clr,
  output logic [CNT_W-1:0]   cnt,
  output logic               cnt_en,
  output logic               trig_flag
);
  logic        lvl;
  logic        rise;
  slave_mode_e mode_e;

  assign mode_e = slave_mode_e'(mode);

  tsg_trig_front #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W),
    .STAGES  (SYNC_STAGES)
  ) u_front (
    .clk      (clk),
    .rst      (rst),
    .trig_in  (trig_in),
    .src_sel  (src_sel),
    .trig_inv (trig_inv),
    .lvl      (lvl),
    .rise     (rise)
  );

  tsg_enable_ctl #(
    .SEL_W    (SEL_W),
    .EDGE_SRC (EDGE_SRC),
    .SWEV_SRC (SWEV_SRC)
  ) u_enable (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_e),
    .src_sel (src_sel),
    .lvl     (lvl),
    .rise    (rise),
    .sw_stop (sw_stop),
    .en      (cnt_en)
  );

  tsg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk (clk),
    .rst (rst),
    .en  (cnt_en),
    .cnt (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst)           trig_flag <= 1'b0;
    else if (rise)     trig_flag <= 1'b1;
    else if (flag_clr) trig_flag <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (trig_flag && !flag_clr) |=> trig_flag); // R10
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (rise && flag_clr) |=> trig_flag); // R11
endmodule

// File: tb/tsg_top_tb.sv
module tsg_top_tb;
  localparam int CNT_W = 8;
  localparam int NSRC  = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic [NSRC-1:0]  trig_in;
  logic [1:0]       src_sel;
  logic             trig_inv;
  logic             mode;
  logic             sw_stop;
  logic             flag_clr;
  logic [CNT_W-1:0] cnt;
  logic             cnt_en;
  logic             trig_flag;

  int checks = 0;
  int errors = 0;
  logic [CNT_W-1:0] v;

  always #2 clk = ~clk;

  tsg_top #(.CNT_W(CNT_W), .NUM_SRC(NSRC)) u_dut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .src_sel(src_sel),
    .trig_inv(trig_inv), .mode(mode), .sw_stop(sw_stop), .flag_clr(flag_clr),
    .cnt(cnt), .cnt_en(cnt_en), .trig_flag(trig_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R12 reset cnt", cnt, 0);
    chk("R12 reset en", cnt_en, 0);
    chk("R12 reset flag", trig_flag, 0);
  endtask

  task automatic t_gated_count();
    mode = 1'b0; src_sel = 2'd1; trig_inv = 1'b0;
    trig_in[1] = 1'b1;
    tick(2);
    chk("R9 no enable after two edges", cnt_en, 0);
    tick(1);
    chk("R9 enable after third edge", cnt_en, 1);
    chk("R10 flag set by rise", trig_flag, 1);
    v = cnt;
    tick(10);
    chk("R1 ten steps", cnt, int'(v) + 10);
  endtask

  task automatic t_gated_hold();
    trig_in[1] = 1'b0;
    tick(3);
    chk("R2 enable drops with level", cnt_en, 0);
    v = cnt;
    chk("R2 value kept nonzero", (v != 0), 1);
    tick(5);
    chk("R2 frozen value", cnt, v);
    sw_stop = 1'b1;
    tick(1);
    sw_stop = 1'b0;
    chk("R6 stop ignored in gated mode", cnt_en, 0);
  endtask

  task automatic t_polarity();
    trig_inv = 1'b1;
    tick(3);
    chk("R3 inverted low line counts", cnt_en, 1);
    trig_inv = 1'b0;
    tick(3);
    chk("R3 restored polarity stops", cnt_en, 0);
  endtask

  task automatic t_edge_bar();
    src_sel = 2'd0;
    trig_in[0] = 1'b1;
    tick(3);
    chk("R7 edge source refused", cnt_en, 0);
    v = cnt;
    tick(4);
    chk("R7 counter unchanged", cnt, v);
    trig_in[0] = 1'b0;
    src_sel = 2'd1;
    tick(4);
  endtask

  task automatic t_resume();
    mode = 1'b1;
    tick(2);
    v = cnt;
    trig_in[1] = 1'b1;
    tick(3);
    chk("R4 edge sets enable", cnt_en, 1);
    chk("R4 resumes from held value", cnt, v);
    tick(4);
    chk("R4 counting continues", cnt, int'(v) + 4);
    trig_in[1] = 1'b0;
    tick(5);
    chk("R5 low trigger keeps enable", cnt_en, 1);
  endtask

  task automatic t_stop();
    sw_stop = 1'b1;
    tick(1);
    sw_stop = 1'b0;
    chk("R6 stop clears enable", cnt_en, 0);
    v = cnt;
    tick(4);
    chk("R6 held after stop", cnt, v);
  endtask

  task automatic t_swev_src();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk("R10 flag cleared", trig_flag, 0);
    src_sel = 2'd3;
    trig_in[3] = 1'b1;
    tick(3);
    chk("R8 update source no resume", cnt_en, 0);
    chk("R10 flag set from any source", trig_flag, 1);
    tick(3);
    chk("R8 still stopped", cnt_en, 0);
    trig_in[3] = 1'b0;
    tick(3);
  endtask

  task automatic t_collide();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    src_sel = 2'd2;
    trig_in[2] = 1'b1;
    tick(2);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk("R11 set wins over clear", trig_flag, 1);
    chk("R4 enable from line 2", cnt_en, 1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk("R10 lone clear", trig_flag, 0);
  endtask

  task automatic t_wrap();
    v = cnt;
    tick(300);
    chk("R12 wrap modulo", cnt, (int'(v) + 300) % 256);
  endtask

  initial begin
    rst = 1'b1; trig_in = '0; src_sel = 2'd1; trig_inv = 1'b0;
    mode = 1'b0; sw_stop = 1'b0; flag_clr = 1'b0;
    tick(3);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_gated_count();
    t_gated_hold();
    t_polarity();
    t_edge_bar();
    t_resume();
    t_stop();
    t_swev_src();
    t_collide();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule